// File: doc/BRIEF.md
# Tagged Branch Target Table

This block keeps a small direct-mapped table of branch destinations so that the fetch stage can learn, in the same cycle it presents a PC, where a previously taken branch at that PC went. Each entry is selected by the low word-address bits of the PC and holds a valid flag, the whole word address of the branch that filled it, and the 32-bit destination. The lookup side compares the stored address against the full lookup PC. It reports a hit only on an exact match, so an entry left by a different branch that shares the same slot is never used.

The fill side is driven from decode. When the instruction there is a branch and it resolves taken, its PC and its computed destination are written into the slot picked by its PC. Branches that fall through, and non-branch instructions, leave the table untouched. A lookup and a fill can occur in the same cycle. If they hit the same slot, the lookup sees the contents from before the fill. A miss tells the caller to fall back to a safe sequential fetch. Choosing between the stored destination and PC+4, predicting direction, and flushing wrong-path work are all left to surrounding logic.

Top module: `tgt_buffer`

## Requirements
- R1: After reset, and until the first fill, every lookup reports `lk_hit` low.
- R2: A fill (`up_is_branch`=1, `up_taken`=1) of PC p with destination d makes a lookup of p, from the next cycle on, report `lk_hit`=1 and `lk_target`=d.
- R3: A branch that resolves not taken (`up_is_branch`=1, `up_taken`=0) writes nothing. An empty slot stays empty, and an occupied slot keeps its old destination.
- R4: With `up_is_branch`=0, nothing is written, whatever the value of `up_taken`.
- R5: Two PCs that differ only above the index bits share a slot. Looking up one while the other is stored misses, and filling one evicts the other.
- R6: PC bits [1:0] are ignored on both the lookup and the fill side. The slot index is PC bits [IDX_W+1:2].
- R7: When a lookup and a fill address the same slot in one cycle, the lookup returns the contents from before the fill. The new contents show from the next cycle.
- R8: The lookup result is combinational from `lk_pc`, with no read register. `lk_target` reads zero whenever `lk_hit` is low.
- R9: Fills to different slots do not disturb each other, including the first and last slots.
- R10: Asserting reset empties every slot, so previously stored PCs miss after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears all valid flags |
| lk_pc | input | PC_W | PC presented by the fetch stage |
| lk_hit | output | 1 | Stored tag matches the whole lookup PC |
| lk_target | output | TGT_W | Stored destination on a hit, zero otherwise |
| up_is_branch | input | 1 | Decode-stage instruction is a branch |
| up_taken | input | 1 | Decode-stage branch resolved taken |
| up_pc | input | PC_W | PC of the decode-stage branch |
| up_target | input | TGT_W | Destination computed for that branch |

## Verification
The assertions take for granted that the fill inputs are quiet during reset. They also assume the block sees at least one clock edge with reset low before it is released. They hold for any fill pattern, because each one compares the lookup outputs only with the fill of the immediately preceding cycle, or with an idle previous cycle. The stimulus changes inputs only on falling edges, holds the fill controls at zero while reset is applied, and issues every fill as a single-cycle pulse. It includes one deliberate collision of a lookup and a fill on the same slot.

// File: rtl/tgtbuf_pkg.sv
// Package: shared constants for the tagged branch target table.
// Assumes instructions are word aligned, so the lowest address bits carry no information.
package tgtbuf_pkg;
    localparam int ALIGN_W = 2;   // address bits below a word boundary
endpackage

// File: rtl/tgtbuf_split.sv
// Module: tgtbuf_split
// Splits a PC into the slot index and the word-address tag.
// Assumes word-aligned PCs; bits below ALIGN_W are dropped.
module tgtbuf_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 7,
    localparam int TAG_W = PC_W - tgtbuf_pkg::ALIGN_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    localparam int LSB = tgtbuf_pkg::ALIGN_W;

    logic unused_align;

    // Slot index comes from the low word-address bits.
    assign idx = pc[LSB+IDX_W-1:LSB];
    // Tag is the whole word address.
    assign tag = pc[PC_W-1:LSB];
    // Byte offset bits are intentionally discarded.
    assign unused_align = ^pc[LSB-1:0];
endmodule

// File: rtl/tgtbuf_store.sv
// Module: tgtbuf_store
// Storage for the table: per-slot valid flag, tag and destination.
// Provides one combinational read port and one clocked write port.
// A read in the cycle of a write to the same slot sees the old contents.
// Only the valid flags are reset; tag and destination need no reset.
module tgtbuf_store #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 30,
    parameter int TGT_W = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt
);
    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [TGT_W-1:0] tgt_mem [DEPTH];

    // Valid flags: cleared by reset, set when a slot is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and destination arrays: written on a fill, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            tgt_mem[wr_idx] <= wr_tgt;
        end
    end

    // Read port: asynchronous, so it returns pre-write contents.
    always_comb begin
        rd_vld = vld_q[rd_idx];
        rd_tag = tag_mem[rd_idx];
        rd_tgt = tgt_mem[rd_idx];
    end
endmodule

// File: rtl/tgtbuf_cmp.sv
// Module: tgtbuf_cmp
// Decides the hit and gates the destination.
// A hit needs a valid slot whose tag equals the probe tag; on a miss the destination reads zero.
module tgtbuf_cmp #(
    parameter int TAG_W = 30,
    parameter int TGT_W = 32
) (
    input  logic             vld,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] probe_tag,
    input  logic [TGT_W-1:0] stored_tgt,
    output logic             hit,
    output logic [TGT_W-1:0] tgt
);
    // Full-tag compare plus zeroing of the destination on a miss.
    always_comb begin
        hit = vld && (stored_tag == probe_tag);
        tgt = hit ? stored_tgt : '0;
    end
endmodule

// File: rtl/tgt_buffer.sv
// Module: tgt_buffer (top)
// Direct-mapped branch destination table with full-address tags.
// Lookups come from fetch every cycle; fills come from decode for taken branches only.
// Assumes word-aligned PCs and a synchronous active-low reset.
module tgt_buffer #(
    parameter int IDX_W = 7,
    parameter int PC_W  = 32,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic [TGT_W-1:0] lk_target,
    input  logic             up_is_branch,
    input  logic             up_taken,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [TGT_W-1:0] up_target
);
    localparam int TAG_W = PC_W - tgtbuf_pkg::ALIGN_W;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             fill;
    logic             rd_vld;
    logic [TAG_W-1:0] rd_tag;
    logic [TGT_W-1:0] rd_tgt;

    // Only a taken branch allocates a slot.
    assign fill = up_is_branch && up_taken;

    tgtbuf_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lk_split (
        .pc  (lk_pc),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    tgtbuf_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_up_split (
        .pc  (up_pc),
        .idx (up_idx),
        .tag (up_tag)
    );

    tgtbuf_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_idx),
        .rd_vld (rd_vld),
        .rd_tag (rd_tag),
        .rd_tgt (rd_tgt),
        .wr_en  (fill),
        .wr_idx (up_idx),
        .wr_tag (up_tag),
        .wr_tgt (up_target)
    );

    tgtbuf_cmp #(.TAG_W(TAG_W), .TGT_W(TGT_W)) u_cmp (
        .vld        (rd_vld),
        .stored_tag (rd_tag),
        .probe_tag  (lk_tag),
        .stored_tgt (rd_tgt),
        .hit        (lk_hit),
        .tgt        (lk_target)
    );
endmodule

// File: rtl/tgt_buffer_chk.sv
// Module: tgt_buffer_chk
// Assertion checker for tgt_buffer, bound to every instance of the top.
// Assumes fill controls are low during reset.
module tgt_buffer_chk #(
    parameter int PC_W  = 32,
    parameter int TGT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_hit,
    input logic [TGT_W-1:0] lk_target,
    input logic             up_is_branch,
    input logic             up_taken,
    input logic [PC_W-1:0]  up_pc,
    input logic [TGT_W-1:0] up_target
);
    logic wr_seen;
    logic settled;
    logic wr_ev;
    logic unused_low;

    assign wr_ev      = up_is_branch && up_taken;
    assign unused_low = ^up_pc[1:0];

    // Records whether any fill happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_seen <= 1'b0;
        else if (wr_ev) wr_seen <= 1'b1;
    end

    // Marks that the previous sampled cycle was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) settled <= 1'b0;
        else settled <= 1'b1;
    end

    a_r1_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_seen |-> !lk_hit);

    a_r2_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && wr_ev) |=>
        ((lk_pc[PC_W-1:2] != $past(up_pc[PC_W-1:2])) ||
         (lk_hit && (lk_target == $past(up_target)))));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !$past(wr_ev) && $stable(lk_pc)) |->
        ($stable(lk_hit) && $stable(lk_target)));

    a_r6_offset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !$past(wr_ev) && $stable(lk_pc[PC_W-1:2])) |->
        ($stable(lk_hit) && $stable(lk_target)));
endmodule

bind tgt_buffer tgt_buffer_chk #(.PC_W(PC_W), .TGT_W(TGT_W)) u_chk (.*);

// File: tb/tgt_buffer_bench.sv
`timescale 1ns/1ps
module tgt_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        up_is_branch = 1'b0;
    logic        up_taken = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_target = '0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tgt_buffer u_tgt_buffer (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_target(lk_target), .up_is_branch(up_is_branch), .up_taken(up_taken),
        .up_pc(up_pc), .up_target(up_target)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lookup in the current low clock phase; outputs are combinational.
    task automatic look(input string req, input logic [31:0] pc,
                        input logic hit, input logic [31:0] tgt);
        lk_pc = pc;
        #0.5;
        chk({req, " hit"}, {31'b0, lk_hit}, {31'b0, hit});
        chk({req, " target"}, lk_target, tgt);
    endtask

    // One-cycle fill pulse; returns at the following falling edge.
    task automatic put(input logic [31:0] pc, input logic [31:0] tgt,
                       input logic br, input logic tk);
        @(negedge clk);
        up_pc = pc; up_target = tgt; up_is_branch = br; up_taken = tk;
        @(negedge clk);
        up_is_branch = 1'b0; up_taken = 1'b0;
    endtask

    task automatic t_reset_state;   // R1
        @(negedge clk);
        look("R1 pc0", 32'h0, 1'b0, 32'h0);
        look("R1 pc1000", 32'h1000, 1'b0, 32'h0);
        look("R1 pcmax", 32'hFFFF_FFFC, 1'b0, 32'h0);
    endtask

    task automatic t_install;       // R2, R8
        put(32'h1000, 32'h8000, 1'b1, 1'b1);
        look("R2 installed", 32'h1000, 1'b1, 32'h8000);
        look("R8 other pc same cycle", 32'h2000, 1'b0, 32'h0);
        look("R8 back", 32'h1000, 1'b1, 32'h8000);
    endtask

    task automatic t_not_taken;     // R3
        put(32'h2004, 32'h9000, 1'b1, 1'b0);
        look("R3 empty stays", 32'h2004, 1'b0, 32'h0);
        put(32'h1000, 32'hAAA0, 1'b1, 1'b0);
        look("R3 occupied kept", 32'h1000, 1'b1, 32'h8000);
    endtask

    task automatic t_non_branch;    // R4
        put(32'h3008, 32'h7000, 1'b0, 1'b1);
        look("R4 non-branch", 32'h3008, 1'b0, 32'h0);
        put(32'h1000, 32'h7770, 1'b0, 1'b1);
        look("R4 occupied kept", 32'h1000, 1'b1, 32'h8000);
    endtask

    task automatic t_alias;         // R5
        @(negedge clk);
        look("R5 alias miss", 32'h1200, 1'b0, 32'h0);
        put(32'h1200, 32'h4444, 1'b1, 1'b1);
        look("R5 new owner", 32'h1200, 1'b1, 32'h4444);
        look("R5 evicted", 32'h1000, 1'b0, 32'h0);
    endtask

    task automatic t_low_bits;      // R6
        @(negedge clk);
        look("R6 lookup offset", 32'h1203, 1'b1, 32'h4444);
        put(32'h0503, 32'h0600, 1'b1, 1'b1);
        look("R6 fill offset", 32'h0500, 1'b1, 32'h0600);
    endtask

    task automatic t_independent;   // R9
        put(32'h1004, 32'h1111, 1'b1, 1'b1);
        put(32'h01FC, 32'h2222, 1'b1, 1'b1);
        look("R9 slot0", 32'h1200, 1'b1, 32'h4444);
        look("R9 slot1", 32'h1004, 1'b1, 32'h1111);
        look("R9 slot127", 32'h01FC, 1'b1, 32'h2222);
    endtask

    task automatic t_collide;       // R7
        @(negedge clk);
        up_pc = 32'h1200; up_target = 32'h5555; up_is_branch = 1'b1; up_taken = 1'b1;
        look("R7 old contents", 32'h1200, 1'b1, 32'h4444);
        @(negedge clk);
        up_is_branch = 1'b0; up_taken = 1'b0;
        look("R7 new contents", 32'h1200, 1'b1, 32'h5555);
    endtask

    task automatic t_reset_clear;   // R10
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        look("R10 slot0", 32'h1200, 1'b0, 32'h0);
        look("R10 slot1", 32'h1004, 1'b0, 32'h0);
        look("R10 slot127", 32'h01FC, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_install();
        t_not_taken();
        t_non_branch();
        t_alias();
        t_low_bits();
        t_independent();
        t_collide();
        t_reset_clear();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule